// File: doc/BRIEF.md
# Dual-Mode Line Byte Serializer and Deserializer

This block sits between a byte-oriented MAC datapath and an Ethernet PHY line interface. On the transmit side it takes bytes through a valid/ready handshake. In MII mode it sends each byte as two 4-bit nibbles, and in RMII mode as four 2-bit dibits. It holds the transmit-enable line high for the whole burst of back-to-back bytes. On the receive side it samples the line data while the receive-valid line is high and rebuilds whole bytes. Each complete byte is presented with a one-cycle strobe.

Both modes send the least significant bits first. One static input selects the mode. The block takes that input only while it is idle, so a frame always keeps the mode it started with. In RMII mode one 50 MHz reference clock, shared with the PHY, drives both directions. In MII mode the same single clock is assumed to be the line clock.

A frame on transmit continues for as long as the MAC side offers the next byte in the one cycle it is asked for. When no byte is offered in that cycle, the frame ends. This covers both the normal end of a frame and an underrun.

Top module: `mii_rmii_byte_codec`

## Requirements
- R1: While reset is held and right after it, `line_tx_en` is 0, `mac_tx_ready` is 1 and `mac_rx_strobe` is 0.
- R2: With `mode_rmii`=0 (MII), a byte is sent in two cycles on `line_txd[3:0]`: bits 3:0 first, then bits 7:4. Byte 8'b10011101 is sent as 4'b1101 and then 4'b1001.
- R3: With `mode_rmii`=1 (RMII), a byte is sent in four cycles on `line_txd[1:0]` in the order bits 1:0, 3:2, 5:4, 7:6, with `line_txd[3:2]` held at 0. Byte 8'b10011101 is sent as 01, 11, 01, 10.
- R4: `line_tx_en` rises in the cycle after a byte is accepted. It stays high with no gap while every following byte is accepted on time. It falls in the cycle after the last line cycle of a byte for which no next byte was offered.
- R5: `mac_tx_ready` is 1 while transmit is idle. While sending, it is 1 only in the last line cycle of the current byte. A byte is taken only when `mac_tx_valid` and `mac_tx_ready` are both 1, and a byte offered while ready is 0 never reaches the line.
- R6: In MII mode, `line_rxd[3:0]` sampled while `line_rx_dv` is 1 fills bits 3:0 of a byte, then bits 7:4.
- R7: In RMII mode, `line_rxd[1:0]` fills bits 1:0, 3:2, 5:4, 7:6 in arrival order, and `line_rxd[3:2]` is ignored.
- R8: `mac_rx_strobe` is high for exactly one cycle, the cycle after the last nibble or dibit of a byte is sampled. `mac_rx_data` then carries that byte and holds it until the next strobe.
- R9: When `line_rx_dv` falls before a byte is complete, the partial byte is dropped with no strobe. The next byte starts again from bits 1:0 or 3:0.
- R10: The mode applied to a frame is the value of `mode_rmii` at the clock edge that starts it: the first accepted transmit byte, or the first sample with `line_rx_dv` high. Changes while either direction is busy take effect only at the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line and MAC clock (the shared reference clock in RMII mode) |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_rmii | input | 1 | Line mode select: 0 MII nibbles, 1 RMII dibits |
| mac_tx_data | input | 8 | Byte offered for transmission |
| mac_tx_valid | input | 1 | Byte offer is valid |
| mac_tx_ready | output | 1 | Block can take a byte this cycle |
| line_tx_en | output | 1 | Transmit enable toward the PHY |
| line_txd | output | 4 | Transmit line data, low two bits only in RMII mode |
| line_rx_dv | input | 1 | Receive data valid from the PHY |
| line_rxd | input | 4 | Receive line data, low two bits only in RMII mode |
| mac_rx_data | output | 8 | Most recently rebuilt receive byte |
| mac_rx_strobe | output | 1 | One-cycle pulse marking a new receive byte |

## Verification
The bench builds the block with its default parameters: 8-bit bytes, 4-bit MII lanes and 2-bit RMII lanes. At that size every byte value fits in a single frame, so all 256 values go through both directions in both modes. Every nibble and dibit position is checked cycle by cycle against shifts computed in the bench. The small unit counts (two and four per byte) mean that every partial-byte length before a receive-valid drop can be tried. Mode flips are also placed inside frames in both directions.

// File: rtl/line_codec_pkg.sv
package line_codec_pkg;

    typedef enum logic {
        LINE_MII  = 1'b0,
        LINE_RMII = 1'b1
    } line_mode_e;

endpackage

// File: rtl/line_tx_serializer.sv
module line_tx_serializer
    import line_codec_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int MII_W  = 4,
    parameter int RMII_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  line_mode_e        mode,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output logic              line_en,
    output logic [MII_W-1:0]  line_d
);

    localparam int MII_UNITS  = BYTE_W / MII_W;
    localparam int RMII_UNITS = BYTE_W / RMII_W;
    localparam int CNT_W      = (RMII_UNITS > 1) ? $clog2(RMII_UNITS) : 1;

    typedef struct packed {
        logic              active;
        logic [BYTE_W-1:0] shreg;
        logic [CNT_W-1:0]  cnt;
    } tx_state_t;

    tx_state_t st_d, st_q;
    logic      last_unit;

    always_comb begin
        st_d = st_q;

        if (mode == LINE_RMII) begin
            last_unit = (st_q.cnt == CNT_W'(RMII_UNITS - 1));
        end else begin
            last_unit = (st_q.cnt == CNT_W'(MII_UNITS - 1));
        end

        in_ready = !st_q.active || last_unit;

        if (in_valid && in_ready) begin
            st_d.active = 1'b1;
            st_d.shreg  = in_data;
            st_d.cnt    = '0;
        end else if (st_q.active) begin
            if (last_unit) begin
                st_d.active = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
                if (mode == LINE_RMII) begin
                    st_d.shreg = st_q.shreg >> RMII_W;
                end else begin
                    st_d.shreg = st_q.shreg >> MII_W;
                end
            end
        end

        line_en = st_q.active;
        for (int j = 0; j < MII_W; j++) begin
            line_d[j] = st_q.active && ((mode == LINE_MII) || (j < RMII_W))
                        && st_q.shreg[j];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/line_rx_deserializer.sv
module line_rx_deserializer
    import line_codec_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int MII_W  = 4,
    parameter int RMII_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  line_mode_e        mode,
    input  logic              line_dv,
    input  logic [MII_W-1:0]  line_d,
    output logic              in_frame,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_strobe
);

    localparam int MII_UNITS  = BYTE_W / MII_W;
    localparam int RMII_UNITS = BYTE_W / RMII_W;
    localparam int CNT_W      = (RMII_UNITS > 1) ? $clog2(RMII_UNITS) : 1;

    typedef struct packed {
        logic              in_frame;
        logic [BYTE_W-1:0] shreg;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] data;
        logic              strobe;
    } rx_state_t;

    rx_state_t         st_d, st_q;
    logic              last_unit;
    logic [BYTE_W-1:0] assembled;

    always_comb begin
        st_d          = st_q;
        st_d.strobe   = 1'b0;
        st_d.in_frame = line_dv;

        if (mode == LINE_RMII) begin
            last_unit = (st_q.cnt == CNT_W'(RMII_UNITS - 1));
            assembled = {line_d[RMII_W-1:0], st_q.shreg[BYTE_W-1:RMII_W]};
        end else begin
            last_unit = (st_q.cnt == CNT_W'(MII_UNITS - 1));
            assembled = {line_d, st_q.shreg[BYTE_W-1:MII_W]};
        end

        if (line_dv) begin
            st_d.shreg = assembled;
            if (last_unit) begin
                st_d.data   = assembled;
                st_d.strobe = 1'b1;
                st_d.cnt    = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else begin
            st_d.cnt = '0;
        end

        in_frame   = st_q.in_frame;
        out_data   = st_q.data;
        out_strobe = st_q.strobe;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/mii_rmii_byte_codec.sv
module mii_rmii_byte_codec
    import line_codec_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int MII_W  = 4,
    parameter int RMII_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_rmii,
    input  logic [BYTE_W-1:0] mac_tx_data,
    input  logic              mac_tx_valid,
    output logic              mac_tx_ready,
    output logic              line_tx_en,
    output logic [MII_W-1:0]  line_txd,
    input  logic              line_rx_dv,
    input  logic [MII_W-1:0]  line_rxd,
    output logic [BYTE_W-1:0] mac_rx_data,
    output logic              mac_rx_strobe
);

    typedef struct packed {
        line_mode_e mode;
    } top_state_t;

    top_state_t st_d, st_q;
    line_mode_e mode_q;
    line_mode_e mode_eff;
    logic       rx_in_frame;
    logic       busy;

    always_comb begin
        st_d     = st_q;
        busy     = line_tx_en || rx_in_frame;
        mode_eff = busy ? st_q.mode : line_mode_e'(mode_rmii);
        st_d.mode = mode_eff;
        mode_q   = st_q.mode;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: LINE_MII};
        end else begin
            st_q <= st_d;
        end
    end

    line_tx_serializer #(
        .BYTE_W (BYTE_W),
        .MII_W  (MII_W),
        .RMII_W (RMII_W)
    ) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode_eff),
        .in_data  (mac_tx_data),
        .in_valid (mac_tx_valid),
        .in_ready (mac_tx_ready),
        .line_en  (line_tx_en),
        .line_d   (line_txd)
    );

    line_rx_deserializer #(
        .BYTE_W (BYTE_W),
        .MII_W  (MII_W),
        .RMII_W (RMII_W)
    ) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode_eff),
        .line_dv    (line_rx_dv),
        .line_d     (line_rxd),
        .in_frame   (rx_in_frame),
        .out_data   (mac_rx_data),
        .out_strobe (mac_rx_strobe)
    );

endmodule

// File: rtl/mii_rmii_byte_codec_checker.sv
module mii_rmii_byte_codec_checker #(
    parameter int MII_W  = 4,
    parameter int RMII_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tx_valid,
    input logic             tx_ready,
    input logic             tx_en,
    input logic [MII_W-1:0] txd,
    input logic             rx_dv,
    input logic             rx_strobe,
    input logic             mode_q
);

    p_idle_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |-> tx_ready);

    p_accept_starts_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && tx_ready |=> tx_en);

    p_no_gap_in_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_en && !tx_ready |=> tx_en);

    p_rmii_upper_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_en && mode_q |-> (txd[MII_W-1:RMII_W] == '0));

    p_strobe_needs_dv_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_strobe |-> $past(rx_dv));

    p_strobe_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_strobe |=> !rx_strobe);

    p_mode_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_en && $past(tx_en) |-> $stable(mode_q));

endmodule

bind mii_rmii_byte_codec mii_rmii_byte_codec_checker #(
    .MII_W  (MII_W),
    .RMII_W (RMII_W)
) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_valid  (mac_tx_valid),
    .tx_ready  (mac_tx_ready),
    .tx_en     (line_tx_en),
    .txd       (line_txd),
    .rx_dv     (line_rx_dv),
    .rx_strobe (mac_rx_strobe),
    .mode_q    (mode_q)
);

// File: tb/mii_rmii_byte_codec_test.sv
module mii_rmii_byte_codec_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_rmii = 1'b0;
    logic [7:0] mac_tx_data = '0;
    logic       mac_tx_valid = 1'b0;
    logic       mac_tx_ready;
    logic       line_tx_en;
    logic [3:0] line_txd;
    logic       line_rx_dv = 1'b0;
    logic [3:0] line_rxd = '0;
    logic [7:0] mac_rx_data;
    logic       mac_rx_strobe;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    mii_rmii_byte_codec uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .mode_rmii     (mode_rmii),
        .mac_tx_data   (mac_tx_data),
        .mac_tx_valid  (mac_tx_valid),
        .mac_tx_ready  (mac_tx_ready),
        .line_tx_en    (line_tx_en),
        .line_txd      (line_txd),
        .line_rx_dv    (line_rx_dv),
        .line_rxd      (line_rxd),
        .mac_rx_data   (mac_rx_data),
        .mac_rx_strobe (mac_rx_strobe)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Transmit a frame of n bytes; byte i = (base + i*step) mod 256.
    task automatic tx_frame(input bit m, input int n, input int base, input int step, input bit flip);
        int w = m ? 2 : 4;
        int units = 8 / w;
        int mask = m ? 3 : 15;
        string tag = flip ? "R10" : (m ? "R3" : "R2");
        mode_rmii    = m;
        mac_tx_valid = 1'b1;
        mac_tx_data  = 8'(base);
        chk("R5", "ready while idle", int'(mac_tx_ready), 1);
        @(negedge clk);
        for (int i = 0; i < n; i++) begin
            int b = (base + i * step) & 255;
            for (int u = 0; u < units; u++) begin
                chk("R4", "tx_en inside frame", int'(line_tx_en), 1);
                chk(tag, "txd unit", int'(line_txd), (b >> (u * w)) & mask);
                if (flip && i == 1 && u == 0) mode_rmii = !m;
                if (u == units - 1) begin
                    chk("R5", "ready on last unit", int'(mac_tx_ready), 1);
                    if (i < n - 1) begin
                        mac_tx_valid = 1'b1;
                        mac_tx_data  = 8'((base + (i + 1) * step) & 255);
                    end else begin
                        mac_tx_valid = 1'b0;
                    end
                end else begin
                    chk("R5", "ready low mid byte", int'(mac_tx_ready), 0);
                    mac_tx_valid = 1'b1;
                    mac_tx_data  = 8'(~b);
                end
                @(negedge clk);
            end
        end
        chk("R4", "tx_en after last byte", int'(line_tx_en), 0);
    endtask

    // Receive a frame of n bytes; byte i = (base + i*step) mod 256.
    task automatic rx_frame(input bit m, input int n, input int base, input int step, input bit flip);
        int w = m ? 2 : 4;
        int units = 8 / w;
        int mask = m ? 3 : 15;
        int last_b = 0;
        string tag = flip ? "R10" : (m ? "R7" : "R6");
        mode_rmii = m;
        for (int i = 0; i < n; i++) begin
            int b = (base + i * step) & 255;
            last_b = b;
            for (int u = 0; u < units; u++) begin
                int unit_v = (b >> (u * w)) & mask;
                line_rx_dv = 1'b1;
                line_rxd   = m ? 4'(unit_v | ((~unit_v & 3) << 2)) : 4'(unit_v);
                @(negedge clk);
                if (flip && i == 1 && u == 0) mode_rmii = !m;
                if (u == units - 1) begin
                    chk("R8", "strobe after last unit", int'(mac_rx_strobe), 1);
                    chk(tag, "rebuilt byte", int'(mac_rx_data), b);
                end else begin
                    chk("R8", "no strobe mid byte", int'(mac_rx_strobe), 0);
                end
            end
        end
        line_rx_dv = 1'b0;
        line_rxd   = '0;
        @(negedge clk);
        chk("R8", "strobe gone after frame", int'(mac_rx_strobe), 0);
        chk("R8", "byte held", int'(mac_rx_data), last_b);
    endtask

    // k units of junk, a one-cycle drop of rx_dv, then a full byte b.
    task automatic rx_partial(input bit m, input int k, input int b);
        int w = m ? 2 : 4;
        int units = 8 / w;
        int mask = m ? 3 : 15;
        mode_rmii = m;
        for (int u = 0; u < k; u++) begin
            line_rx_dv = 1'b1;
            line_rxd   = 4'hF;
            @(negedge clk);
            chk("R9", "no strobe on partial", int'(mac_rx_strobe), 0);
        end
        line_rx_dv = 1'b0;
        @(negedge clk);
        chk("R9", "no strobe on drop", int'(mac_rx_strobe), 0);
        for (int u = 0; u < units; u++) begin
            line_rx_dv = 1'b1;
            line_rxd   = 4'((b >> (u * w)) & mask);
            @(negedge clk);
            if (u < units - 1) chk("R9", "no strobe mid byte", int'(mac_rx_strobe), 0);
        end
        chk("R9", "strobe after restart", int'(mac_rx_strobe), 1);
        chk("R9", "byte after restart", int'(mac_rx_data), b);
        line_rx_dv = 1'b0;
        line_rxd   = '0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "tx_en in reset", int'(line_tx_en), 0);
        chk("R1", "ready in reset", int'(mac_tx_ready), 1);
        chk("R1", "strobe in reset", int'(mac_rx_strobe), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "tx_en after reset", int'(line_tx_en), 0);
        chk("R1", "strobe after reset", int'(mac_rx_strobe), 0);

        // Worked example byte 8'b10011101 in both modes.
        tx_frame(1'b0, 1, 8'h9D, 0, 1'b0);
        tx_frame(1'b1, 1, 8'h9D, 0, 1'b0);
        rx_frame(1'b0, 1, 8'h9D, 0, 1'b0);
        rx_frame(1'b1, 1, 8'h9D, 0, 1'b0);

        // Every byte value, back to back, in both modes.
        tx_frame(1'b0, 256, 0, 1, 1'b0);
        tx_frame(1'b1, 256, 0, 1, 1'b0);
        rx_frame(1'b0, 256, 0, 1, 1'b0);
        rx_frame(1'b1, 256, 0, 1, 1'b0);

        // Other patterns.
        tx_frame(1'b1, 64, 8'hA5, 37, 1'b0);
        rx_frame(1'b0, 64, 8'h5A, 91, 1'b0);

        // Mode input flipped inside frames.
        tx_frame(1'b0, 4, 8'h3C, 17, 1'b1);
        tx_frame(1'b1, 4, 8'hC3, 29, 1'b1);
        rx_frame(1'b0, 4, 8'h81, 13, 1'b1);
        rx_frame(1'b1, 4, 8'h7E, 53, 1'b1);

        // Partial bytes dropped, every length.
        for (int k = 1; k < 2; k++) rx_partial(1'b0, k, 8'hB4 + k);
        for (int k = 1; k < 4; k++) rx_partial(1'b1, k, 8'h4B + k);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule